// File: doc/BRIEF.md
# Program Memory Download Port

This block arbitrates the external program-memory bus between two masters. In normal operation the processor's instruction-fetch path owns the bus: the fetch address is passed straight through, and chip-select is raised only for fetches that land in external memory. When download mode is enabled and the direct-access bit is clear, a small set of host-writable byte registers takes over the address and data buses. This lets a host load code into the external memory one word at a time.

The host stores a word by writing four byte registers: address low, address high, data low and finally data high. The external write strobe is raised for exactly as long as the host strobe is held on the data-high register, whatever the length of that pulse. No wait state of any kind stretches or shortens it. During that pulse the data bus already carries the byte being written. The host register bus has no back-pressure: every write is taken in the cycle it is presented. While download mode is set, chip-select stays on without a break.

Top module: `prog_bus_loader`

## Requirements
- R1: After reset, all four host byte registers read as zero, so in download mode the memory address and data buses are 0x0000.
- R2: With download mode set and direct access clear, the memory address is {byte at host 0x45, byte at host 0x44}. The memory data is {byte at 0x47, byte at 0x46}, and the data-enable output is high.
- R3: In download mode with direct access clear, the write strobe is high in exactly those cycles in which the host strobe is high with host address 0x47, for any pulse length.
- R4: The write strobe never rises for a host write to any address other than 0x47, and never rises when download mode is off or direct access is set.
- R5: During a host write to 0x47 in download mode, data bits 15:8 show the host data byte in the same cycle. Bits 7:0 show the stored 0x46 byte.
- R6: While download mode is set, chip-select is high in every cycle, including when direct access is set.
- R7: With download mode off, chip-select is high only when a fetch is requested and either the split-map pin is low or fetch address bit 15 is set (0x8000 to 0xFFFF).
- R8: Unless download mode is set with direct access clear, the memory address equals the fetch address, and the data bus is 0x0000 with data-enable low.
- R9: Host writes update the byte registers in any mode. Writes to host addresses outside 0x44 to 0x47 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 8 | Host register address |
| host_wr_i | input | 1 | Host write strobe, active high, level |
| host_data_i | input | 8 | Host write data byte |
| dl_mode_i | input | 1 | Download mode enable |
| dsp_access_i | input | 1 | Direct-access bit; blocks host bus ownership when set |
| split_map_i | input | 1 | High: only upper half of address space is external |
| fetch_addr_i | input | 16 | Processor program-fetch address |
| fetch_req_i | input | 1 | Processor program-fetch request |
| mem_addr_o | output | 16 | External memory address |
| mem_data_o | output | 16 | External memory write data |
| mem_data_oe_o | output | 1 | Data bus drive enable |
| mem_we_o | output | 1 | External memory write strobe |
| mem_cs_o | output | 1 | External program chip-select |

## Verification
The host write to the data-high register and the external memory write fall in the same cycle. The block must place the new high byte on the data bus while it raises the strobe, not one clock later when the register has captured it. The bench provokes this with data-high pulses of one, three and five cycles. On every falling edge it compares the bus and strobe against a model that bypasses the live host byte, and it counts strobe cycles against the pulse length. A second overlap is a fetch request arriving while download mode holds chip-select. That case is judged by chip-select staying high regardless of the fetch address.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  localparam int HOST_AW = 8;
  localparam logic [HOST_AW-1:0] REG_BASE = 8'h44;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  // Slot order is behaviour: the data-high slot triggers the memory write.
  typedef enum logic [SLOT_W-1:0] {
    SLOT_ADDR_LO = 2'd0,
    SLOT_ADDR_HI = 2'd1,
    SLOT_DATA_LO = 2'd2,
    SLOT_DATA_HI = 2'd3
  } slot_e;
endpackage

// File: rtl/pbl_host_regs.sv
module pbl_host_regs
  import pbl_pkg::*;
#(
  parameter int HB_W = 8,
  localparam int WORD_W = 2 * HB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               host_wr_i,
  input  logic [HB_W-1:0]    host_data_i,
  output logic [WORD_W-1:0]  word_addr_o,
  output logic [WORD_W-1:0]  word_data_o,
  output logic               dhi_wr_o
);
  logic [NUM_SLOTS-1:0][HB_W-1:0] slot_q;
  logic [HOST_AW-1:0]             offset;
  logic                           in_window;
  logic [SLOT_W-1:0]              slot_idx;

  assign offset    = host_addr_i - REG_BASE;
  assign in_window = (host_addr_i >= REG_BASE) && (offset < HOST_AW'(NUM_SLOTS));
  assign slot_idx  = offset[SLOT_W-1:0];
  assign dhi_wr_o  = host_wr_i && in_window && (slot_idx == SLOT_DATA_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (host_wr_i && in_window) begin
      slot_q[slot_idx] <= host_data_i;
    end
  end

  assign word_addr_o = {slot_q[SLOT_ADDR_HI], slot_q[SLOT_ADDR_LO]};
  // The high byte bypasses its register while it is being written.
  assign word_data_o = {(dhi_wr_o ? host_data_i : slot_q[SLOT_DATA_HI]),
                        slot_q[SLOT_DATA_LO]};
endmodule

// File: rtl/pbl_fetch_dec.sv
module pbl_fetch_dec #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          fetch_req_i,
  input  logic          split_map_i,
  output logic          ext_hit_o
);
  logic upper_half;
  assign upper_half = fetch_addr_i[AW-1];
  assign ext_hit_o  = fetch_req_i && (!split_map_i || upper_half);
endmodule

// File: rtl/pbl_bus_mux.sv
module pbl_bus_mux #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          dl_mode_i,
  input  logic          dl_active_i,
  input  logic [AW-1:0] dl_addr_i,
  input  logic [DW-1:0] dl_data_i,
  input  logic          dhi_wr_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          ext_hit_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_data_oe_o,
  output logic          mem_we_o,
  output logic          mem_cs_o
);
  always_comb begin
    if (dl_active_i) begin
      mem_addr_o    = dl_addr_i;
      mem_data_o    = dl_data_i;
      mem_data_oe_o = 1'b1;
      mem_we_o      = dhi_wr_i;
    end else begin
      mem_addr_o    = fetch_addr_i;
      mem_data_o    = '0;
      mem_data_oe_o = 1'b0;
      mem_we_o      = 1'b0;
    end
    mem_cs_o = dl_mode_i || ext_hit_i;
  end
endmodule

// File: rtl/prog_bus_loader.sv
module prog_bus_loader
  import pbl_pkg::*;
#(
  parameter int HB_W = 8,
  localparam int WORD_W = 2 * HB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               host_wr_i,
  input  logic [HB_W-1:0]    host_data_i,
  input  logic               dl_mode_i,
  input  logic               dsp_access_i,
  input  logic               split_map_i,
  input  logic [WORD_W-1:0]  fetch_addr_i,
  input  logic               fetch_req_i,
  output logic [WORD_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_data_o,
  output logic               mem_data_oe_o,
  output logic               mem_we_o,
  output logic               mem_cs_o
);
  logic [WORD_W-1:0] dl_addr;
  logic [WORD_W-1:0] dl_data;
  logic              dhi_wr;
  logic              ext_hit;
  logic              dl_active;

  assign dl_active = dl_mode_i && !dsp_access_i;

  pbl_host_regs #(.HB_W(HB_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr_i (host_addr_i),
    .host_wr_i   (host_wr_i),
    .host_data_i (host_data_i),
    .word_addr_o (dl_addr),
    .word_data_o (dl_data),
    .dhi_wr_o    (dhi_wr)
  );

  pbl_fetch_dec #(.AW(WORD_W)) u_dec (
    .fetch_addr_i (fetch_addr_i),
    .fetch_req_i  (fetch_req_i),
    .split_map_i  (split_map_i),
    .ext_hit_o    (ext_hit)
  );

  pbl_bus_mux #(.AW(WORD_W), .DW(WORD_W)) u_mux (
    .dl_mode_i     (dl_mode_i),
    .dl_active_i   (dl_active),
    .dl_addr_i     (dl_addr),
    .dl_data_i     (dl_data),
    .dhi_wr_i      (dhi_wr),
    .fetch_addr_i  (fetch_addr_i),
    .ext_hit_i     (ext_hit),
    .mem_addr_o    (mem_addr_o),
    .mem_data_o    (mem_data_o),
    .mem_data_oe_o (mem_data_oe_o),
    .mem_we_o      (mem_we_o),
    .mem_cs_o      (mem_cs_o)
  );
endmodule

// File: rtl/prog_bus_loader_chk.sv
module prog_bus_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  host_addr_i,
  input logic        host_wr_i,
  input logic [7:0]  host_data_i,
  input logic        dl_mode_i,
  input logic        dsp_access_i,
  input logic        split_map_i,
  input logic [15:0] fetch_addr_i,
  input logic        fetch_req_i,
  input logic [15:0] mem_addr_o,
  input logic [15:0] mem_data_o,
  input logic        mem_data_oe_o,
  input logic        mem_we_o,
  input logic        mem_cs_o
);
  assert_cs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dl_mode_i |-> mem_cs_o);

  assert_we_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (host_wr_i && host_addr_i == 8'h47 && dl_mode_i && !dsp_access_i));

  assert_we_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_addr_i == 8'h47 && dl_mode_i && !dsp_access_i) |-> mem_we_o);

  assert_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dl_mode_i && !dsp_access_i) |-> (!mem_data_oe_o && mem_data_o == 16'h0000
                                       && mem_addr_o == fetch_addr_i));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_mode_i && !dsp_access_i && $past(dl_mode_i && !dsp_access_i) && !$past(host_wr_i))
      |-> $stable(mem_addr_o));

  assert_cs_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dl_mode_i && fetch_req_i && !split_map_i) |-> mem_cs_o);

  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dl_mode_i && !fetch_req_i) |-> !mem_cs_o);
endmodule

bind prog_bus_loader prog_bus_loader_chk u_chk (.*);

// File: tb/prog_bus_loader_tb.sv
module prog_bus_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic        host_wr = 1'b0;
  logic [7:0]  host_data = 8'h00;
  logic        dl_mode = 1'b0;
  logic        dsp_access = 1'b0;
  logic        split_map = 1'b0;
  logic [15:0] fetch_addr = 16'h0000;
  logic        fetch_req = 1'b0;
  logic [15:0] mem_addr, mem_data;
  logic        mem_oe, mem_we, mem_cs;

  int n_checks = 0;
  int n_fail = 0;
  int we_cycles = 0;
  logic [7:0] m_alo = 0, m_ahi = 0, m_dlo = 0, m_dhi = 0;

  always #10 clk = ~clk;

  prog_bus_loader u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr), .host_wr_i(host_wr),
    .host_data_i(host_data), .dl_mode_i(dl_mode), .dsp_access_i(dsp_access),
    .split_map_i(split_map), .fetch_addr_i(fetch_addr), .fetch_req_i(fetch_req),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_data_oe_o(mem_oe),
    .mem_we_o(mem_we), .mem_cs_o(mem_cs)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of the byte registers (R9: any mode, window 0x44..0x47 only)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_alo = 0; m_ahi = 0; m_dlo = 0; m_dhi = 0;
    end else if (host_wr) begin
      case (host_addr)
        8'h44: m_alo = host_data;
        8'h45: m_ahi = host_data;
        8'h46: m_dlo = host_data;
        8'h47: m_dhi = host_data;
        default: ;
      endcase
    end
  end

  // Cycle-by-cycle comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic act, wr_hi;
      logic [15:0] e_addr, e_data;
      logic e_cs;
      act   = dl_mode && !dsp_access;
      wr_hi = host_wr && host_addr == 8'h47;
      e_addr = act ? {m_ahi, m_alo} : fetch_addr;
      e_data = act ? {(wr_hi ? host_data : m_dhi), m_dlo} : 16'h0000;
      e_cs   = dl_mode ? 1'b1 : (fetch_req && (!split_map || fetch_addr[15]));
      check(act ? "R2 addr" : "R8 addr", 32'(mem_addr), 32'(e_addr));
      check(act ? (wr_hi ? "R5 data" : "R2 data") : "R8 data", 32'(mem_data), 32'(e_data));
      check(act ? "R2 oe" : "R8 oe", 32'(mem_oe), 32'(act));
      check(act ? "R3 we" : "R4 we", 32'(mem_we), 32'(act && wr_hi));
      check(dl_mode ? "R6 cs" : "R7 cs", 32'(mem_cs), 32'(e_cs));
      if (mem_we) we_cycles++;
    end
  end

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d, input int len);
    @(posedge clk); #2;
    host_addr = a; host_data = d; host_wr = 1'b1;
    repeat (len) @(posedge clk);
    #2 host_wr = 1'b0;
  endtask

  task automatic store_word(input logic [15:0] a, input logic [15:0] d, input int len);
    hwrite(8'h44, a[7:0], 1);
    hwrite(8'h45, a[15:8], 1);
    hwrite(8'h46, d[7:0], 2);
    we_cycles = 0;
    hwrite(8'h47, d[15:8], len);
    @(negedge clk);
    check("R3 strobe width", 32'(we_cycles), 32'(len));
    check("R2 word addr", 32'(mem_addr), 32'(a));
    check("R2 word data", 32'(mem_data), 32'(d));
  endtask

  initial begin
    int spin = 0;
    while (spin < 20000) begin
      @(posedge clk);
      spin++;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    dl_mode = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset addr", 32'(mem_addr), 32'h0);
    check("R1 reset data", 32'(mem_data), 32'h0);

    store_word(16'h1234, 16'hABCD, 1);
    store_word(16'h8001, 16'h5A5A, 3);
    store_word(16'hFFFF, 16'h0001, 5);

    // R9: outside-window write changes nothing
    hwrite(8'h48, 8'hEE, 2);
    hwrite(8'h43, 8'hEE, 2);
    @(negedge clk);
    check("R9 addr kept", 32'(mem_addr), 32'hFFFF);
    check("R9 data kept", 32'(mem_data), 32'h0001);

    // R4: long write to address low gives no strobe
    we_cycles = 0;
    hwrite(8'h44, 8'h10, 3);
    @(negedge clk);
    check("R4 no strobe on 0x44", 32'(we_cycles), 32'h0);

    // Direct access set: no ownership, cs still held (R6), no strobe (R4)
    #2 dsp_access = 1'b1; fetch_addr = 16'h0123; fetch_req = 1'b0; split_map = 1'b1;
    we_cycles = 0;
    hwrite(8'h47, 8'h77, 2);
    @(negedge clk);
    check("R4 no strobe direct", 32'(we_cycles), 32'h0);
    check("R6 cs with direct", 32'(mem_cs), 32'h1);

    // Normal mode fetch decoding (R7)
    #2 dsp_access = 1'b0; dl_mode = 1'b0;
    fetch_addr = 16'h1000; fetch_req = 1'b1; split_map = 1'b1;
    @(negedge clk); check("R7 low half split", 32'(mem_cs), 32'h0);
    #2 fetch_addr = 16'h9000;
    @(negedge clk); check("R7 high half split", 32'(mem_cs), 32'h1);
    #2 fetch_addr = 16'h1000; split_map = 1'b0;
    @(negedge clk); check("R7 low half all-ext", 32'(mem_cs), 32'h1);
    #2 fetch_req = 1'b0;
    @(negedge clk); check("R7 no request", 32'(mem_cs), 32'h0);

    // R9: register write in normal mode, no strobe (R4), seen after re-entering download
    we_cycles = 0;
    hwrite(8'h46, 8'h3C, 1);
    hwrite(8'h47, 8'hC3, 2);
    @(negedge clk);
    check("R4 no strobe normal", 32'(we_cycles), 32'h0);
    #2 dl_mode = 1'b1;
    @(negedge clk);
    check("R9 data from normal-mode writes", 32'(mem_data), 32'hC33C);
    check("R6 cs in download", 32'(mem_cs), 32'h1);

    store_word(16'h0042, 16'h9988, 2);
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule